// File: doc/BRIEF.md
# Parallel EEPROM Host Programmer

This block is a synchronous controller that sits on the host side of a byte-wide parallel EEPROM. It drives the address lines, the three active-low strobes (chip select, output enable, write strobe) and a split data bus made of an output value, an output-enable and an input value. It performs sequential reads, and it also performs single-byte or page writes. Requests arrive on a valid/ready command port. Write data arrives on a valid/ready byte stream. Read data leaves on a valid/ready byte stream.

Every bus phase is a whole number of clock cycles set by a parameter: address/data setup before the write strobe falls, write-strobe low time, hold time after it rises, read access time and the idle gap between reads. A write request first collects all of its bytes into an internal page buffer. It then loads them back to back, so each strobe falls well inside the device's byte-load window. After the last byte the controller waits for the load window to close. It then polls the last written address until the device reports the write complete, or until a timeout elapses.

Back-pressure rules: `cmd_ready` is high only while the controller is idle. A command is taken on the cycle where `cmd_valid` and `cmd_ready` are both high. `wr_ready` is high only while a write is collecting its bytes. The host may leave gaps in `wr_valid` without harm, because nothing is put on the bus until every byte is held. `rd_valid` holds its byte until `rd_ready` accepts it, and the next read cycle starts only after that.

Top module: `eeprom_host_prog`

## Requirements
- R1: After reset, `cmd_ready` is 1, all three strobes are 1 (inactive), `mem_dq_oe` is 0 and `rd_valid` is 0.
- R2: A read command with `cmd_len` = n-1 returns n bytes on the read stream, from addresses `cmd_addr`, `cmd_addr`+1, … (full-width increment). Each byte is sampled after T_ACC cycles with chip select and output enable low and the write strobe high.
- R3: During every write strobe, output enable is high, chip select is low and the host drives data. The strobe stays low for at least T_WP cycles, and address and data stay unchanged while it is low.
- R4: The host never drives the data bus while output enable is low.
- R5: A write with `cmd_len` = n-1 (n from 1 to 64) stores n bytes. Byte i goes to the same 64-byte page as `cmd_addr`, at offset (`cmd_addr` offset + i) mod 64. No other page changes.
- R6: All bytes of one write command reach the device in a single load: the time from one strobe rise to the next strobe fall stays below BLC_CYC cycles, even when the host stalls `wr_valid`.
- R7: With `use_toggle` = 0, completion is declared only when a poll read of the last written address returns bit 7 equal to bit 7 of the last written byte. `wr_done` then pulses for one cycle.
- R8: With `use_toggle` = 1, completion is declared only when two consecutive poll reads return the same bit 6, even if bit 7 already matches.
- R9: If completion is not seen within TIMEOUT_CYC cycles after the load ends, `wr_timeout` pulses for one cycle instead of `wr_done`, and the controller returns to idle.
- R10: `cmd_ready` stays low from command acceptance until completion or timeout, and a new command is accepted afterwards.
- R11: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| cmd_write | input | 1 | 1 = page write, 0 = read |
| cmd_addr | input | ADDR_W | Start address |
| cmd_len | input | PW | Byte count minus one |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken when valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| use_toggle | input | 1 | Completion test: 0 = bit 7 match, 1 = bit 6 stable |
| wr_done | output | 1 | One-cycle pulse: write completed |
| wr_timeout | output | 1 | One-cycle pulse: completion not seen in time |
| mem_addr | output | ADDR_W | Device address |
| mem_dq_out | output | 8 | Data driven to device |
| mem_dq_oe | output | 1 | Host data driver enable |
| mem_dq_in | input | 8 | Data from device |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
The hardest case to reach from the ports is the toggle-bit completion. It only matters when bit 7 already looks finished while the device is still busy. The bench responder has a mode that returns the true bit 7 during its busy time, so a controller that used the wrong test would finish early. The bench then checks that `wr_done` comes only after the responder's busy period ends. The timeout path comes from a second responder mode that never leaves busy. A page write that starts at offset 40 and is fed with stalls exercises both the offset wrap inside the page and the single-load rule.

// File: rtl/ephp_pkg.sv
package ephp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_WSU,
    ST_WLO,
    ST_WHI,
    ST_SETTLE,
    ST_PACC,
    ST_PGAP,
    ST_RACC,
    ST_RGAP,
    ST_ROUT
  } ephp_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ephp_timer.sv
module ephp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // Phase counter never wraps below zero
  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(cnt) == '0 && !$past(load)) |-> cnt == '0); // R3
endmodule

// File: rtl/ephp_page_buf.sv
module ephp_page_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/ephp_poll_judge.sv
module ephp_poll_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample,
  input  logic dq7,
  input  logic dq6,
  input  logic exp7,
  input  logic use_toggle,
  output logic hit
);
  logic have_prev;
  logic prev6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev6     <= 1'b0;
    end else if (clear) begin
      have_prev <= 1'b0;
    end else if (sample) begin
      have_prev <= 1'b1;
      prev6     <= dq6;
    end
  end

  always_comb begin
    if (use_toggle) hit = have_prev && (dq6 == prev6);
    else            hit = (dq7 == exp7);
  end
endmodule

// File: rtl/eeprom_host_prog.sv
module eeprom_host_prog
  import ephp_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int PAGE_BYTES  = 64,
  parameter int T_SU        = 1,
  parameter int T_WP        = 5,
  parameter int T_WH        = 2,
  parameter int T_ACC       = 10,
  parameter int T_GAP       = 2,
  parameter int BLC_CYC     = 5000,
  parameter int TIMEOUT_CYC = 500000,
  localparam int PW         = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PW-1:0]     cmd_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  input  logic              use_toggle,
  output logic              wr_done,
  output logic              wr_timeout,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [7:0]        mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  localparam int TMAX = imax(imax(imax(T_SU, T_WP), imax(T_WH, T_ACC)), imax(T_GAP, BLC_CYC));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int OW   = $clog2(TIMEOUT_CYC + 1);
  localparam int GW   = $clog2(BLC_CYC + 1);
  localparam int LW   = $clog2(T_WP + 2);

  ephp_state_e       state, state_nx;
  logic [ADDR_W-1:0] base_q;
  logic [PW-1:0]     len_q, idx_q;
  logic [7:0]        rdat_q;
  logic [OW-1:0]     to_cnt;
  logic              done_q;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          buf_we;
  logic [7:0]    buf_rdata;
  logic          judge_clear, judge_sample, judge_hit;
  logic          idx_last;

  logic [ADDR_W-1:0] page_addr, lin_addr;

  assign idx_last  = (idx_q == len_q);
  assign page_addr = {base_q[ADDR_W-1:PW], base_q[PW-1:0] + idx_q};
  assign lin_addr  = base_q + {{(ADDR_W-PW){1'b0}}, idx_q};

  ephp_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  ephp_page_buf #(.DEPTH(PAGE_BYTES), .DW(8)) u_buf (
    .clk(clk), .we(buf_we), .widx(idx_q), .wdata(wr_data),
    .ridx(idx_q), .rdata(buf_rdata)
  );

  ephp_poll_judge u_judge (
    .clk(clk), .rst_n(rst_n), .clear(judge_clear), .sample(judge_sample),
    .dq7(mem_dq_in[7]), .dq6(mem_dq_in[6]), .exp7(buf_rdata[7]),
    .use_toggle(use_toggle), .hit(judge_hit)
  );

  // Next-state and phase timer loads
  always_comb begin
    state_nx     = state;
    tmr_load     = 1'b0;
    tmr_val      = '0;
    buf_we       = 1'b0;
    judge_clear  = 1'b0;
    judge_sample = 1'b0;
    unique case (state)
      ST_IDLE: if (cmd_valid) begin
        if (cmd_write) state_nx = ST_FILL;
        else begin
          state_nx = ST_RACC;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_ACC - 1);
        end
      end
      ST_FILL: if (wr_valid) begin
        buf_we = 1'b1;
        if (idx_last) begin
          state_nx = ST_WSU;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_SU - 1);
        end
      end
      ST_WSU: if (tmr_zero) begin
        state_nx = ST_WLO;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_WP - 1);
      end
      ST_WLO: if (tmr_zero) begin
        state_nx = ST_WHI;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_WH - 1);
      end
      ST_WHI: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (idx_last) begin
          state_nx    = ST_SETTLE;
          tmr_val     = TW'(BLC_CYC - 1);
          judge_clear = 1'b1;
        end else begin
          state_nx = ST_WSU;
          tmr_val  = TW'(T_SU - 1);
        end
      end
      ST_SETTLE: if (tmr_zero) begin
        state_nx = ST_PACC;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_ACC - 1);
      end
      ST_PACC: if (tmr_zero) begin
        judge_sample = 1'b1;
        state_nx     = ST_PGAP;
        tmr_load     = 1'b1;
        tmr_val      = TW'(T_GAP - 1);
      end
      ST_PGAP: if (tmr_zero) begin
        if (done_q || (to_cnt >= OW'(TIMEOUT_CYC))) state_nx = ST_IDLE;
        else begin
          state_nx = ST_PACC;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_ACC - 1);
        end
      end
      ST_RACC: if (tmr_zero) begin
        state_nx = ST_RGAP;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_GAP - 1);
      end
      ST_RGAP: if (tmr_zero) state_nx = ST_ROUT;
      ST_ROUT: if (rd_ready) begin
        if (idx_last) state_nx = ST_IDLE;
        else begin
          state_nx = ST_RACC;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_ACC - 1);
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  // Control and data registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      base_q     <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      rdat_q     <= '0;
      to_cnt     <= '0;
      done_q     <= 1'b0;
      wr_done    <= 1'b0;
      wr_timeout <= 1'b0;
    end else begin
      state      <= state_nx;
      wr_done    <= 1'b0;
      wr_timeout <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          base_q <= cmd_addr;
          len_q  <= cmd_len;
          idx_q  <= '0;
        end
        ST_FILL: if (wr_valid) idx_q <= idx_last ? '0 : idx_q + 1'b1;
        ST_WHI: if (tmr_zero) begin
          if (idx_last) begin
            to_cnt <= '0;
            done_q <= 1'b0;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_RACC: if (tmr_zero) rdat_q <= mem_dq_in;
        ST_ROUT: if (rd_ready && !idx_last) idx_q <= idx_q + 1'b1;
        default: ;
      endcase
      if (state == ST_SETTLE || state == ST_PACC || state == ST_PGAP) begin
        if (to_cnt < OW'(TIMEOUT_CYC)) to_cnt <= to_cnt + 1'b1;
      end
      if (judge_sample) done_q <= judge_hit;
      if (state == ST_PGAP && tmr_zero) begin
        if (done_q) wr_done <= 1'b1;
        else if (to_cnt >= OW'(TIMEOUT_CYC)) wr_timeout <= 1'b1;
      end
    end
  end

  // Bus and stream decode
  logic in_wr, in_poll, in_rd;
  assign in_wr   = (state == ST_WSU) || (state == ST_WLO) || (state == ST_WHI);
  assign in_poll = (state == ST_PACC);
  assign in_rd   = (state == ST_RACC);

  assign mem_ce_n   = !(in_wr || in_poll || in_rd);
  assign mem_oe_n   = !(in_poll || in_rd);
  assign mem_we_n   = (state != ST_WLO);
  assign mem_dq_oe  = in_wr;
  assign mem_dq_out = buf_rdata;
  assign mem_addr   = (state == ST_RACC || state == ST_RGAP || state == ST_ROUT) ? lin_addr : page_addr;

  assign cmd_ready = (state == ST_IDLE);
  assign wr_ready  = (state == ST_FILL);
  assign rd_valid  = (state == ST_ROUT);
  assign rd_data   = rdat_q;

  // Checker state: strobe width, load gaps
  logic [LW-1:0] we_lo_cnt;
  logic [GW-1:0] gap_cnt;
  logic          load_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      gap_cnt   <= '0;
      load_open <= 1'b0;
    end else begin
      if (!mem_we_n) begin
        if (we_lo_cnt < LW'(T_WP + 1)) we_lo_cnt <= we_lo_cnt + 1'b1;
      end else we_lo_cnt <= '0;
      if (!mem_we_n) gap_cnt <= '0;
      else if (gap_cnt < GW'(BLC_CYC)) gap_cnt <= gap_cnt + 1'b1;
      if (!mem_we_n) load_open <= 1'b1;
      else if (!in_wr) load_open <= 1'b0;
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R4
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> we_lo_cnt >= LW'(T_WP)); // R3
  AST_WRITE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe)); // R3
  AST_WE_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R3
  AST_LOAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_we_n) && load_open) |-> gap_cnt < GW'(BLC_CYC)); // R6
  AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe)); // R10
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && wr_timeout)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R11
endmodule

// File: tb/eeprom_host_prog_tb_top.sv
module eeprom_host_prog_tb_top;
  localparam int AW = 15, PB = 64, PW = 6, TWP = 5;
  localparam int BLC = 64, TMO = 3000, RESP_BLC = 40, BUSY = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cmd_valid = 0, cmd_write = 0, wr_valid = 0, rd_ready = 1, use_toggle = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [PW-1:0] cmd_len = '0;
  logic [7:0] wr_data = '0, mem_dq_in = '0;
  logic cmd_ready, wr_ready, rd_valid, wr_done, wr_timeout;
  logic [7:0] rd_data, mem_dq_out;
  logic [AW-1:0] mem_addr;
  logic mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;

  eeprom_host_prog #(.ADDR_W(AW), .PAGE_BYTES(PB), .T_WP(TWP), .BLC_CYC(BLC), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .use_toggle(use_toggle),
    .wr_done(wr_done), .wr_timeout(wr_timeout), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] exp_mem [int];
  function automatic logic [7:0] exp_at(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
  endfunction

  // Behavioural device responder
  logic [7:0] rmem [int];
  int pa[$];
  logic [7:0] pd[$];
  bit stuck = 0, fake7 = 0, busy = 0, tog = 0, rd_prev = 0, we_prev = 1;
  int since = 0, bcnt = 0, lo_cnt = 0, we_min = 1000, busy_end = 0, last_load = 0;
  int viol_cont = 0, viol_frame = 0, viol_stab = 0;
  logic last7 = 0;
  logic [AW-1:0] a_prev = '0;
  logic [7:0] d_prev = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) viol_cont++;
      if (!mem_we_n && (!mem_oe_n || mem_ce_n || !mem_dq_oe)) viol_frame++;
      if (!mem_we_n && !we_prev && (mem_addr != a_prev || mem_dq_out != d_prev)) viol_stab++;
      if (!mem_we_n) lo_cnt++;
      if (!we_prev && mem_we_n) begin
        if (lo_cnt < we_min) we_min = lo_cnt;
        lo_cnt = 0;
        pa.push_back(int'(a_prev));
        pd.push_back(d_prev);
        since = 0;
      end else if (pa.size() > 0 && !busy) begin
        since++;
        if (since == RESP_BLC) begin
          last7 = pd[pd.size()-1][7];
          last_load = pa.size();
          if (!stuck) foreach (pa[k]) rmem[pa[k]] = pd[k];
          pa.delete();
          pd.delete();
          busy = 1;
          bcnt = 0;
        end
      end
      if (busy) begin
        bcnt++;
        if (bcnt >= BUSY && !stuck) begin
          busy = 0;
          busy_end = cyc;
        end
      end
      if (!mem_ce_n && !mem_oe_n && !rd_prev) tog = ~tog;
      rd_prev = !mem_ce_n && !mem_oe_n;
      if (busy) mem_dq_in <= {(fake7 ? last7 : ~last7), tog, 6'h00};
      else mem_dq_in <= rmem.exists(int'(mem_addr)) ? rmem[int'(mem_addr)] : 8'hFF;
      we_prev = mem_we_n;
      a_prev = mem_addr;
      d_prev = mem_dq_out;
    end
  end

  // Scoreboard: driver pushes expected read bytes, monitor pops
  logic [7:0] sbq[$];
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (sbq.size() == 0) check(0, "R2 unexpected read byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = sbq.pop_front();
        check(rd_data == e, "R2/R5 read data", rd_data, e);
      end
    end
  end

  task automatic send_cmd(input bit w, input int a, input int n);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_write = w; cmd_addr = AW'(a); cmd_len = PW'(n - 1);
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic do_write(input int a, input int n, input int seed, input bit upd,
                          output bit got_done, output bit got_to, output int t_end);
    bit rdy_seen = 0;
    int t0;
    send_cmd(1, a, n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 37) & 8'hFF);
      wr_valid = 1; wr_data = b;
      do @(negedge clk); while (!wr_ready);
      @(posedge clk); #1;
      if (upd) exp_mem[(a & ~(PB - 1)) + ((a + i) % PB)] = b;
      if (i % 5 == 4) begin
        wr_valid = 0;
        repeat (3) @(posedge clk);
        #1;
      end
    end
    wr_valid = 0;
    t0 = cyc;
    got_done = 0; got_to = 0;
    forever begin
      @(negedge clk);
      if (wr_done || wr_timeout) break;
      if (cmd_ready) rdy_seen = 1;
    end
    got_done = wr_done; got_to = wr_timeout; t_end = cyc;
    check(!rdy_seen, "R10 cmd_ready low while busy", rdy_seen, 0);
    if (got_to) check((t_end - t0) >= TMO, "R9 timeout not early", t_end - t0, TMO);
  endtask

  task automatic do_read(input int a, input int n);
    for (int i = 0; i < n; i++) sbq.push_back(exp_at((a + i) % (1 << AW)));
    send_cmd(0, a, n);
    while (sbq.size() != 0) @(negedge clk);
  endtask

  bit gd, gt;
  int te;

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(cmd_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
          "R1 reset state", {cmd_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 6'b111100);

    // single byte, data polling
    do_write('h0123, 1, 'hA5, 1, gd, gt, te);
    check(gd && !gt, "R7 data-poll completion", {gd, gt}, 2'b10);
    check(te > busy_end, "R7 done after device busy ends", te, busy_end);
    check(last_load == 1, "R6 single load byte count", last_load, 1);
    do_read('h0123, 1);

    // full page from offset 40 with stalls on the byte stream
    do_write('h0268, 64, 'h3C, 1, gd, gt, te);
    check(gd && !gt, "R7 page completion", {gd, gt}, 2'b10);
    check(last_load == 64, "R6 all bytes in one load", last_load, 64);
    do_read('h0240, 64);   // R5 wrapped offsets within the page
    do_read('h0280, 1);    // R5 neighbouring page untouched

    // toggle mode with bit 7 already matching while busy
    fake7 = 1; use_toggle = 1;
    do_write('h1000, 3, 'h81, 1, gd, gt, te);
    check(gd && !gt, "R8 toggle completion", {gd, gt}, 2'b10);
    check(te > busy_end, "R8 done only after toggling stops", te, busy_end);
    fake7 = 0; use_toggle = 0;

    // read back-pressure
    rd_ready = 0;
    for (int i = 0; i < 2; i++) sbq.push_back(exp_at('h1000 + i));
    send_cmd(0, 'h1000, 2);
    do @(negedge clk); while (!rd_valid);
    begin
      logic [7:0] held;
      bit ok = 1;
      held = rd_data;
      repeat (4) begin
        @(negedge clk);
        if (!rd_valid || rd_data != held) ok = 0;
      end
      check(ok, "R11 hold under back-pressure", rd_data, held);
    end
    @(posedge clk); #1 rd_ready = 1;
    while (sbq.size() != 0) @(negedge clk);
    check(1, "R2 sequential read drained", 0, 0);

    // device never finishes
    stuck = 1;
    do_write('h2000, 1, 'h77, 0, gd, gt, te);
    check(gt && !gd, "R9 timeout pulse", {gd, gt}, 2'b01);
    stuck = 0;
    repeat (5) @(negedge clk);

    // new command accepted after timeout
    do_read('h0123, 1);
    check(cmd_ready, "R10 ready after completion", cmd_ready, 1);

    check(viol_cont == 0, "R4 no contention", viol_cont, 0);
    check(we_min >= TWP, "R3 strobe width", we_min, TWP);
    check(viol_frame == 0, "R3 write frame", viol_frame, 0);
    check(viol_stab == 0, "R3 stable during strobe", viol_stab, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=%0d expected<%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule